// File: doc/BRIEF.md
# Serial-to-FIFO Bridge Control Registers

This block is the register front end that a host uses to join a serial controller to a pair of external FIFOs. The external FIFOs are one for transmit and one for receive. It holds two writable registers. The configuration register turns the bridge on, picks which of two receiver channels feeds the receive FIFO, and picks which group of events drives the host interrupt. The FIFO control register carries a reset request for each FIFO and an enable mask for the FIFO interrupt events. Two further read-only registers report the live FIFO flags and the interrupt sources.

Resetting a FIFO is a sequence run by software. The host sets a reset bit, which drives the matching reset output, and later clears the bit to release it. A request to set a reset bit is refused while the bridge is enabled. After a block reset the bridge is disabled and both FIFOs are held in reset until software releases them. While the bridge is enabled, a one-bit switch in the configuration register routes the data and valid of receiver channel A or channel B into the receive FIFO write port.

Top module: `fifo_bridge_ctl`

## Requirements
- R1: After reset, the bridge is disabled (`fifo_en`=0), both `txf_rst` and `rxf_rst` are high, `irq` is low, the configuration register (address 0) reads 0x00 and the FIFO control register (address 1) reads 0x03.
- R2: Configuration register fields: bit 1 is the receive source (1 = channel B, 0 = channel A) and drives `rx_src_b`; bit 2 is the bridge enable and drives `fifo_en`; bits 5:4 are the interrupt source (00 serial controller, 01 FIFO events, 10 line test, 11 none) and drive `int_src`. Bits 7:6, 3 and 0 ignore writes and read 0.
- R3: `rxf_push` and `rxf_wdata` follow channel B valid and data when bit 1 is 1, and channel A when bit 1 is 0. `rxf_push` stays low while the bridge is disabled.
- R4: FIFO control bit 0 is the transmit FIFO reset and bit 1 is the receive FIFO reset. While the bridge is disabled, writing 1 asserts the matching reset output and writing 0 releases it. The two bits act independently.
- R5: While the bridge is enabled, a write that sets FIFO control bit 0 or 1 has no effect: the bit reads back 0 and both reset outputs stay low.
- R6: Address 2 is a read-only FIFO status register holding the live flags (bit 0 transmit empty, bit 1 transmit full, bit 2 receive empty, bit 3 receive full, bits 7:4 zero). Writes to it are ignored.
- R7: Address 3 is the interrupt status register: bit 0 serial controller request, bit 1 line test request, bit 4 transmit empty, bit 5 receive not empty, bit 6 receive full, bit 7 transmit full, bits 3:2 zero. Its bits follow the live inputs, and reading it clears nothing.
- R8: `irq` is registered and reflects, one cycle after its inputs, the selected source: the serial request, the OR of interrupt status bits 7:4 masked by FIFO control bits 7:4, the line test request, or 0 for source 11.
- R9: A read strobe loads `rdata` at the clock edge, and the value holds until the next read.
- R10: FIFO control bits 3:2 ignore writes and read 0. Bits 7:4 store the FIFO event enables whether or not the bridge is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| txf_empty | input | 1 | Transmit FIFO empty flag |
| txf_full | input | 1 | Transmit FIFO full flag |
| rxf_empty | input | 1 | Receive FIFO empty flag |
| rxf_full | input | 1 | Receive FIFO full flag |
| ser_irq | input | 1 | Serial controller interrupt request |
| tst_irq | input | 1 | Line test interrupt request |
| rxa_data | input | DATA_W | Receiver channel A data |
| rxa_valid | input | 1 | Receiver channel A data valid |
| rxb_data | input | DATA_W | Receiver channel B data |
| rxb_valid | input | 1 | Receiver channel B data valid |
| rxf_wdata | output | DATA_W | Receive FIFO write data |
| rxf_push | output | 1 | Receive FIFO write strobe |
| txf_rst | output | 1 | Transmit FIFO reset |
| rxf_rst | output | 1 | Receive FIFO reset |
| fifo_en | output | 1 | Bridge enable to the serial controller side |
| rx_src_b | output | 1 | Receive source select, 1 = channel B |
| int_src | output | 2 | Selected interrupt source |
| irq | output | 1 | Interrupt output |

## Verification
A wrong stored enable or reset bit shows up directly, in the same cycle, on `fifo_en`, `txf_rst` or `rxf_rst`. It also appears in the read data one cycle after a read of the register that holds it. A wrong steering bit sends the other channel's bytes into the receive FIFO at once. A fault in the interrupt mask or source decode appears on `irq` one clock after the source changes. That delay is why each interrupt check waits exactly one cycle after the stimulus, and each case is built so that the source that is not selected would give the opposite level.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        A_CFG   = 2'd0,
        A_CTRL  = 2'd1,
        A_FSTAT = 2'd2,
        A_ISTAT = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_SERIAL = 2'd0,
        SRC_FIFO   = 2'd1,
        SRC_LINE   = 2'd2,
        SRC_NONE   = 2'd3
    } irq_src_e;

    typedef struct packed {
        irq_src_e int_src;
        logic     fifo_en;
        logic     rx_src_b;
    } cfg_t;

    typedef struct packed {
        logic [3:0] ie;
        logic       rx_rst;
        logic       tx_rst;
    } ctrl_t;

    function automatic logic [REG_W-1:0] cfg_to_bus(cfg_t c);
        return {2'b00, c.int_src, 1'b0, c.fifo_en, c.rx_src_b, 1'b0};
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_bus(ctrl_t c);
        return {c.ie, 2'b00, c.rx_rst, c.tx_rst};
    endfunction

endpackage

// File: rtl/bridge_regs.sv
module bridge_regs
    import bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_addr_e        waddr,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg,
    output ctrl_t            ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '{int_src: SRC_SERIAL, fifo_en: 1'b0, rx_src_b: 1'b0};
            ctrl <= '{ie: 4'h0, rx_rst: 1'b1, tx_rst: 1'b1};
        end else if (wr) begin
            case (waddr)
                A_CFG: begin
                    cfg.rx_src_b <= wdata[1];
                    cfg.fifo_en  <= wdata[2];
                    cfg.int_src  <= irq_src_e'(wdata[5:4]);
                end
                A_CTRL: begin
                    ctrl.ie     <= wdata[7:4];
                    // a set request is refused while the bridge is live
                    ctrl.tx_rst <= wdata[0] & ~cfg.fifo_en;
                    ctrl.rx_rst <= wdata[1] & ~cfg.fifo_en;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bridge_irq.sv
module bridge_irq
    import bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             txf_empty,
    input  logic             txf_full,
    input  logic             rxf_empty,
    input  logic             rxf_full,
    input  logic             ser_irq,
    input  logic             tst_irq,
    input  irq_src_e         int_src,
    input  logic [3:0]       ie,
    output logic [REG_W-1:0] fstat,
    output logic [REG_W-1:0] istat,
    output logic             irq
);

    logic [3:0] fifo_evt;
    logic       irq_nxt;

    assign fifo_evt = {txf_full, rxf_full, ~rxf_empty, txf_empty};
    assign fstat    = {4'h0, rxf_full, rxf_empty, txf_full, txf_empty};
    assign istat    = {fifo_evt, 2'b00, tst_irq, ser_irq};

    always_comb begin
        unique case (int_src)
            SRC_SERIAL: irq_nxt = ser_irq;
            SRC_FIFO:   irq_nxt = |(fifo_evt & ie);
            SRC_LINE:   irq_nxt = tst_irq;
            default:    irq_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= irq_nxt;
    end

endmodule

// File: rtl/bridge_rx_steer.sv
module bridge_rx_steer #(
    parameter int DATA_W = 8
) (
    input  logic              en,
    input  logic              sel_b,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_push
);

    assign out_data = sel_b ? b_data : a_data;
    assign out_push = en & (sel_b ? b_valid : a_valid);

endmodule

// File: rtl/fifo_bridge_ctl.sv
module fifo_bridge_ctl
    import bridge_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [7:0]        rdata,
    input  logic              txf_empty,
    input  logic              txf_full,
    input  logic              rxf_empty,
    input  logic              rxf_full,
    input  logic              ser_irq,
    input  logic              tst_irq,
    input  logic [DATA_W-1:0] rxa_data,
    input  logic              rxa_valid,
    input  logic [DATA_W-1:0] rxb_data,
    input  logic              rxb_valid,
    output logic [DATA_W-1:0] rxf_wdata,
    output logic              rxf_push,
    output logic              txf_rst,
    output logic              rxf_rst,
    output logic              fifo_en,
    output logic              rx_src_b,
    output logic [1:0]        int_src,
    output logic              irq
);

    reg_addr_e        a_e;
    cfg_t             cfg;
    ctrl_t            ctrl;
    logic [REG_W-1:0] fstat;
    logic [REG_W-1:0] istat;
    logic [REG_W-1:0] rd_mux;

    assign a_e = reg_addr_e'(addr);

    bridge_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .waddr (a_e),
        .wdata (wdata),
        .cfg   (cfg),
        .ctrl  (ctrl)
    );

    bridge_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .txf_empty (txf_empty),
        .txf_full  (txf_full),
        .rxf_empty (rxf_empty),
        .rxf_full  (rxf_full),
        .ser_irq   (ser_irq),
        .tst_irq   (tst_irq),
        .int_src   (cfg.int_src),
        .ie        (ctrl.ie),
        .fstat     (fstat),
        .istat     (istat),
        .irq       (irq)
    );

    bridge_rx_steer #(.DATA_W(DATA_W)) u_steer (
        .en       (cfg.fifo_en),
        .sel_b    (cfg.rx_src_b),
        .a_data   (rxa_data),
        .a_valid  (rxa_valid),
        .b_data   (rxb_data),
        .b_valid  (rxb_valid),
        .out_data (rxf_wdata),
        .out_push (rxf_push)
    );

    assign fifo_en  = cfg.fifo_en;
    assign rx_src_b = cfg.rx_src_b;
    assign int_src  = cfg.int_src;
    assign txf_rst  = ctrl.tx_rst & ~cfg.fifo_en;
    assign rxf_rst  = ctrl.rx_rst & ~cfg.fifo_en;

    always_comb begin
        unique case (a_e)
            A_CFG:   rd_mux = cfg_to_bus(cfg);
            A_CTRL:  rd_mux = ctrl_to_bus(ctrl);
            A_FSTAT: rd_mux = fstat;
            default: rd_mux = istat;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

endmodule

// File: rtl/fifo_bridge_chk.sv
module fifo_bridge_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] addr,
    input logic       wr,
    input logic       rd,
    input logic [7:0] rdata,
    input logic       fifo_en,
    input logic [1:0] int_src,
    input logic       txf_rst,
    input logic       rxf_rst,
    input logic       irq,
    input logic       tst_irq,
    input logic       txf_empty,
    input logic       txf_full,
    input logic       rxf_empty,
    input logic       rxf_full
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (txf_rst && rxf_rst && !fifo_en));

    p_set_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 2'd1 && fifo_en) |=> (!txf_rst && !rxf_rst));

    p_cfg_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(rd) && $past(addr) == 2'd0) |-> (rdata[7:6] == 2'b00 && !rdata[3] && !rdata[0]));

    p_live_flags_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(rd) && $past(addr) == 2'd2) |->
        (rdata == {4'h0, $past(rxf_full), $past(rxf_empty), $past(txf_full), $past(txf_empty)}));

    p_irq_none_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(int_src) == 2'd3) |-> !irq);

    p_irq_line_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(int_src) == 2'd2) |-> (irq == $past(tst_irq)));

endmodule

bind fifo_bridge_ctl fifo_bridge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr        (wr),
    .rd        (rd),
    .rdata     (rdata),
    .fifo_en   (fifo_en),
    .int_src   (int_src),
    .txf_rst   (txf_rst),
    .rxf_rst   (rxf_rst),
    .irq       (irq),
    .tst_irq   (tst_irq),
    .txf_empty (txf_empty),
    .txf_full  (txf_full),
    .rxf_empty (rxf_empty),
    .rxf_full  (rxf_full)
);

// File: tb/sim_fifo_bridge_ctl.sv
`timescale 1ns/1ps
module sim_fifo_bridge_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata;
    logic       txf_empty = 1'b1, txf_full = 1'b0, rxf_empty = 1'b1, rxf_full = 1'b0;
    logic       ser_irq = 1'b0, tst_irq = 1'b0;
    logic [7:0] rxa_data = '0, rxb_data = '0;
    logic       rxa_valid = 1'b0, rxb_valid = 1'b0;
    logic [7:0] rxf_wdata;
    logic       rxf_push, txf_rst, rxf_rst, fifo_en, rx_src_b, irq;
    logic [1:0] int_src;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    fifo_bridge_ctl #(.DATA_W(8)) u0 (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    // driver: push expected value, monitor compares after the capture edge
    task automatic reg_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; rd = 1'b1;
        step();
        rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 fifo_en", {7'd0, fifo_en}, 8'h00);
        check("R1 resets", {6'd0, txf_rst, rxf_rst}, 8'h03);
        check("R1 irq", {7'd0, irq}, 8'h00);
        reg_rd(2'd0, 8'h00, "R1 cfg read");
        reg_rd(2'd1, 8'h03, "R1 ctrl read");

        // R4 independent reset bits while disabled
        reg_wr(2'd1, 8'h01);
        check("R4 tx only", {6'd0, txf_rst, rxf_rst}, 8'h02);
        reg_wr(2'd1, 8'h02);
        check("R4 rx only", {6'd0, txf_rst, rxf_rst}, 8'h01);
        reg_wr(2'd1, 8'h00);
        check("R4 released", {6'd0, txf_rst, rxf_rst}, 8'h00);

        // R2 configuration fields and reserved bits, R9 read latency
        reg_wr(2'd0, 8'hFF);
        reg_rd(2'd0, 8'h36, "R2 cfg readback");
        check("R2 outputs", {4'd0, fifo_en, rx_src_b, int_src}, 8'h0F);
        ser_irq = 1'b1; tst_irq = 1'b1;
        step();
        check("R8 source none", {7'd0, irq}, 8'h00);
        ser_irq = 1'b0; tst_irq = 1'b0;

        // R5 set refused while enabled, R10 control reserved bits
        reg_wr(2'd1, 8'hFF);
        check("R5 resets low", {6'd0, txf_rst, rxf_rst}, 8'h00);
        reg_rd(2'd1, 8'hF0, "R5 R10 ctrl readback");
        check("R9 rdata held", rdata, 8'hF0);

        // R3 receive steering
        reg_wr(2'd0, 8'h06);
        rxa_data = 8'h11; rxa_valid = 1'b1; rxb_data = 8'h22; rxb_valid = 1'b1;
        #1;
        check("R3 chan B", {rxf_push, rxf_wdata[6:0]}, {1'b1, 7'h22});
        @(negedge clk);
        reg_wr(2'd0, 8'h04);
        #1;
        check("R3 chan A", {rxf_push, rxf_wdata[6:0]}, {1'b1, 7'h11});
        rxa_valid = 1'b0;
        #1;
        check("R3 A idle", {7'd0, rxf_push}, 8'h00);
        @(negedge clk);
        reg_wr(2'd0, 8'h02);
        #1;
        check("R3 disabled", {7'd0, rxf_push}, 8'h00);
        @(negedge clk);
        rxb_valid = 1'b0;

        // R6 live FIFO flags, writes ignored
        txf_empty = 1'b1; txf_full = 1'b0; rxf_empty = 1'b0; rxf_full = 1'b1;
        reg_rd(2'd2, 8'h09, "R6 flags");
        reg_wr(2'd2, 8'hFF);
        reg_rd(2'd2, 8'h09, "R6 after write");

        // R7 interrupt status, reading clears nothing
        ser_irq = 1'b1;
        reg_rd(2'd3, 8'h71, "R7 first read");
        reg_rd(2'd3, 8'h71, "R7 second read");
        rxf_empty = 1'b1; rxf_full = 1'b0;
        reg_rd(2'd3, 8'h11, "R7 live change");

        // R8 source select
        reg_wr(2'd0, 8'h04);
        step();
        check("R8 serial high", {7'd0, irq}, 8'h01);
        ser_irq = 1'b0;
        step();
        check("R8 serial low", {7'd0, irq}, 8'h00);
        tst_irq = 1'b1;
        reg_wr(2'd0, 8'h24);
        step();
        check("R8 line high", {7'd0, irq}, 8'h01);
        tst_irq = 1'b0; ser_irq = 1'b1;
        step();
        check("R8 line ignores serial", {7'd0, irq}, 8'h00);
        ser_irq = 1'b0;
        reg_wr(2'd0, 8'h14);
        step();
        check("R8 fifo tx empty", {7'd0, irq}, 8'h01);
        reg_wr(2'd1, 8'hE0);
        step();
        check("R8 R10 mask off", {7'd0, irq}, 8'h00);
        rxf_empty = 1'b0;
        step();
        check("R8 rx not empty", {7'd0, irq}, 8'h01);

        // R4 reset works again after disable
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd1, 8'h01);
        check("R4 tx reset again", {6'd0, txf_rst, rxf_rst}, 8'h02);
        step();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule